// File: doc/BRIEF.md
# Flash Program and Erase Sequencer with Erase Suspend

This block sits between a CPU bus and a modelled non-volatile byte array. Software writes a small control word that selects one operation: byte program, sector erase, chip erase, or programming of four protection bytes. It then presents the target address and data on the array write port and issues a start command. While the operation runs, the sequencer raises a busy flag. Reads then return the erased value and array writes are discarded. Each operation takes a parameterized number of clock cycles. When it finishes, the selection clears itself and the array returns to ordinary read mode.

A running sector erase can be suspended. While suspended, the busy flag is low and the array can be read. A single nested byte program may also run. A later resume raises busy again, and the erase continues from the cycle count it had left. After reset, and again after a power-down request is released, the block holds busy high for a fixed startup interval.

Control word `ctl_wdata`: bits [2:0] are the operation code (0 none, 1 byte program, 2 sector erase, 3 chip erase, 4 protection program; 5 to 7 act as none). Bit 3 is start. Bit 4 is suspend.

Top module: `flash_seq`

## Requirements
- R1: After reset is released, and after `pwr_down` falls, `busy` is high for exactly T_START cycles. While `pwr_down` is high, `busy` is high on every following cycle and any running operation is abandoned.
- R2: While `busy` is high, `mem_rdata` is 8'hFF. While it is low, `mem_rdata` is the array byte at `mem_addr`. Every array byte reads 8'hFF after reset.
- R3: With byte program, sector erase or protection selected, the first array write latches the target and `busy` is high from the next cycle. A start command with chip erase code raises `busy` on the next cycle.
- R4: A byte program holds `busy` high for exactly T_PROG cycles after its start command. It then leaves the target byte equal to its old value ANDed with the written data.
- R5: A sector erase holds `busy` high for T_SECT cycles. It then sets to 8'hFF every byte whose address matches the target above the low SECT_AW bits, and leaves all other bytes unchanged.
- R6: A chip erase holds `busy` high for T_CHIP cycles, then every array byte reads 8'hFF.
- R7: Protection programming accepts one to four writes in any order while loading. `mem_addr[1:0]` selects protection byte 0 to 3, and byte k is `prot_q[8k+7:8k]`. After T_PROG cycles, each addressed byte becomes old AND data. Unaddressed bytes and the array are unchanged.
- R8: Array writes issued while an operation executes, or while no operation is selected, change no array byte.
- R9: A start command issued with no target latched completes at once. `busy` never rises, nothing changes, and `op_sel` reads 0.
- R10: A suspend command during a sector erase with at least two cycles left makes `busy` low and `suspended` high on the next cycle. The sector contents stay readable and unerased.
- R11: While suspended, only reads, resume and a nested byte program take effect. Chip erase and protection commands are ignored, and `op_sel` stays 2. A nested program takes T_PROG cycles of `busy` and then returns to the suspended state.
- R12: A start command with code 0 or 2 while suspended (and no nested program selected) raises `busy` again and clears `suspended`. The busy cycles before the suspend and after the resume add up to T_SECT.
- R13: `op_sel` shows the selected operation code and returns to 0 when the operation finishes. During a suspend it shows 2, or 1 while a nested program is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_down | input | 1 | Power-down request; startup interval restarts on release |
| ctl_we | input | 1 | Control word write strobe |
| ctl_wdata | input | 5 | Control word: code [2:0], start [3], suspend [4] |
| mem_addr | input | AW | Array address for reads and target writes |
| mem_we | input | 1 | Array write strobe (target latch) |
| mem_wdata | input | 8 | Array write data |
| mem_rdata | output | 8 | Array read data, 8'hFF while busy |
| busy | output | 1 | Operation or startup in progress |
| suspended | output | 1 | A sector erase is suspended |
| op_sel | output | 3 | Currently selected operation code |
| prot_q | output | 32 | The four protection bytes |

## Verification
The checker watches four cycle-level rules at every clock: reads return 8'hFF whenever busy is high, busy is low during a suspend unless a nested program is selected, busy follows a held power-down, and busy rises after a chip-erase start or a resume. It also checks that the selection reads zero whenever busy falls outside a suspend. The exact busy durations, the AND-only update of bytes and protection registers, the sector boundaries, the dropped writes, and the split of erase time across a suspend all depend on data and history. Only the directed bench scenarios can show these, by reading the array back through the port.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

    localparam int NPROT  = 4;
    localparam int PIDX_W = 2;

    typedef enum logic [2:0] {
        OP_NONE = 3'd0,
        OP_PROG = 3'd1,
        OP_SECT = 3'd2,
        OP_CHIP = 3'd3,
        OP_PROT = 3'd4
    } op_e;

    typedef enum logic [2:0] {
        ST_START,
        ST_IDLE,
        ST_LOAD,
        ST_EXEC,
        ST_SUSP,
        ST_SLOAD,
        ST_SPROG
    } state_e;

    typedef struct packed {
        logic susp;
        logic go;
        op_e  code;
    } ctl_cmd_t;

    function automatic ctl_cmd_t decode_ctl(input logic [4:0] w);
        ctl_cmd_t c;
        c.susp = w[4];
        c.go   = w[3];
        case (w[2:0])
            3'd1:    c.code = OP_PROG;
            3'd2:    c.code = OP_SECT;
            3'd3:    c.code = OP_CHIP;
            3'd4:    c.code = OP_PROT;
            default: c.code = OP_NONE;
        endcase
        return c;
    endfunction

    // operations that need a latched target before they can run
    function automatic logic needs_target(input op_e op);
        return (op == OP_PROG) || (op == OP_SECT) || (op == OP_PROT);
    endfunction

    function automatic int max_of4(input int a, input int b, input int c, input int d);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

endpackage

// File: rtl/flash_seq_timer.sv
module flash_seq_timer #(
    parameter int             CW      = 8,
    parameter logic [CW-1:0]  RST_VAL = '0
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    input  logic          dec,
    output logic [CW-1:0] cnt,
    output logic          last
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= RST_VAL;
        end else if (load) begin
            cnt <= load_val;
        end else if (dec && cnt != '0) begin
            cnt <= cnt - CW'(1);
        end
    end

    assign last = (cnt == CW'(1));

endmodule

// File: rtl/flash_seq_fsm.sv
module flash_seq_fsm
    import flash_seq_pkg::*;
#(
    parameter int AW      = 8,
    parameter int CW      = 7,
    parameter int T_START = 20,
    parameter int T_PROG  = 6,
    parameter int T_SECT  = 40,
    parameter int T_CHIP  = 60
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  pwr_down,
    input  logic                  ctl_we,
    input  logic [4:0]            ctl_wdata,
    input  logic                  mem_we,
    input  logic [AW-1:0]         mem_addr,
    input  logic [7:0]            mem_wdata,
    output logic                  busy,
    output logic                  suspended,
    output op_e                   op_sel,
    output logic                  commit,
    output op_e                   commit_kind,
    output logic [AW-1:0]         tgt_addr,
    output logic [7:0]            tgt_data,
    output logic [AW-1:0]         sect_addr,
    output logic [NPROT-1:0]      prot_mask,
    output logic [NPROT-1:0][7:0] prot_data
);

    state_e   st, st_n;
    op_e      sel, sel_n;
    logic     nested, nest_n;
    logic [CW-1:0] erase_left, left_n;
    logic [AW-1:0] ta_n, sa_n;
    logic [7:0]    td_n;
    logic [NPROT-1:0]      pm_n;
    logic [NPROT-1:0][7:0] pd_n;

    logic          t_load, t_dec, t_last;
    logic [CW-1:0] t_val, t_cnt;
    ctl_cmd_t      cmd;

    assign cmd = decode_ctl(ctl_wdata);

    function automatic logic [CW-1:0] run_len(input op_e op);
        case (op)
            OP_SECT: return CW'(T_SECT);
            OP_CHIP: return CW'(T_CHIP);
            default: return CW'(T_PROG);
        endcase
    endfunction

    flash_seq_timer #(
        .CW      (CW),
        .RST_VAL (CW'(T_START))
    ) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (t_load),
        .load_val (t_val),
        .dec      (t_dec),
        .cnt      (t_cnt),
        .last     (t_last)
    );

    always_comb begin
        st_n   = st;
        sel_n  = sel;
        nest_n = nested;
        left_n = erase_left;
        ta_n   = tgt_addr;
        td_n   = tgt_data;
        sa_n   = sect_addr;
        pm_n   = prot_mask;
        pd_n   = prot_data;
        t_load = 1'b0;
        t_val  = '0;
        t_dec  = 1'b0;
        if (pwr_down) begin
            st_n   = ST_START;
            sel_n  = OP_NONE;
            nest_n = 1'b0;
            pm_n   = '0;
            t_load = 1'b1;
            t_val  = CW'(T_START);
        end else begin
            case (st)
                ST_START: begin
                    t_dec = 1'b1;
                    if (t_last) st_n = ST_IDLE;
                end
                ST_IDLE: begin
                    if (ctl_we) begin
                        if (cmd.go) begin
                            if (cmd.code == OP_CHIP) begin
                                sel_n  = OP_CHIP;
                                st_n   = ST_EXEC;
                                t_load = 1'b1;
                                t_val  = CW'(T_CHIP);
                            end else begin
                                sel_n = OP_NONE;   // nothing latched: done at once
                            end
                        end else begin
                            sel_n = cmd.code;
                        end
                    end else if (mem_we && needs_target(sel)) begin
                        st_n = ST_LOAD;
                        case (sel)
                            OP_PROG: begin
                                ta_n = mem_addr;
                                td_n = mem_wdata;
                            end
                            OP_SECT: sa_n = mem_addr;
                            default: begin
                                pm_n[mem_addr[PIDX_W-1:0]] = 1'b1;
                                pd_n[mem_addr[PIDX_W-1:0]] = mem_wdata;
                            end
                        endcase
                    end
                end
                ST_LOAD: begin
                    if (ctl_we && cmd.go) begin
                        st_n   = ST_EXEC;
                        t_load = 1'b1;
                        t_val  = run_len(sel);
                    end else if (mem_we && sel == OP_PROT) begin
                        pm_n[mem_addr[PIDX_W-1:0]] = 1'b1;
                        pd_n[mem_addr[PIDX_W-1:0]] = mem_wdata;
                    end
                end
                ST_EXEC: begin
                    t_dec = 1'b1;
                    if (t_last) begin
                        st_n  = ST_IDLE;
                        sel_n = OP_NONE;
                        pm_n  = '0;
                    end else if (ctl_we && cmd.susp && sel == OP_SECT) begin
                        st_n   = ST_SUSP;
                        left_n = t_cnt - CW'(1);
                    end
                end
                ST_SUSP: begin
                    if (ctl_we) begin
                        if (nested) begin
                            if (cmd.go) nest_n = 1'b0;
                        end else if (!cmd.go && cmd.code == OP_PROG) begin
                            nest_n = 1'b1;
                        end else if (cmd.go && (cmd.code == OP_NONE || cmd.code == OP_SECT)) begin
                            st_n   = ST_EXEC;
                            t_load = 1'b1;
                            t_val  = erase_left;
                        end
                    end else if (mem_we && nested) begin
                        st_n = ST_SLOAD;
                        ta_n = mem_addr;
                        td_n = mem_wdata;
                    end
                end
                ST_SLOAD: begin
                    if (ctl_we && cmd.go) begin
                        st_n   = ST_SPROG;
                        t_load = 1'b1;
                        t_val  = CW'(T_PROG);
                    end
                end
                ST_SPROG: begin
                    t_dec = 1'b1;
                    if (t_last) begin
                        st_n   = ST_SUSP;
                        nest_n = 1'b0;
                    end
                end
                default: st_n = ST_START;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= ST_START;
            sel        <= OP_NONE;
            nested     <= 1'b0;
            erase_left <= '0;
            tgt_addr   <= '0;
            tgt_data   <= '0;
            sect_addr  <= '0;
            prot_mask  <= '0;
            prot_data  <= '0;
        end else begin
            st         <= st_n;
            sel        <= sel_n;
            nested     <= nest_n;
            erase_left <= left_n;
            tgt_addr   <= ta_n;
            tgt_data   <= td_n;
            sect_addr  <= sa_n;
            prot_mask  <= pm_n;
            prot_data  <= pd_n;
        end
    end

    assign busy        = (st == ST_START) || (st == ST_LOAD) || (st == ST_EXEC)
                      || (st == ST_SLOAD) || (st == ST_SPROG);
    assign suspended   = (st == ST_SUSP) || (st == ST_SLOAD) || (st == ST_SPROG);
    assign op_sel      = (st == ST_START) ? OP_NONE : (nested ? OP_PROG : sel);
    assign commit      = ((st == ST_EXEC) || (st == ST_SPROG)) && t_last;
    assign commit_kind = (st == ST_SPROG) ? OP_PROG : sel;

endmodule

// File: rtl/flash_seq_store.sv
module flash_seq_store
    import flash_seq_pkg::*;
#(
    parameter int AW      = 8,
    parameter int SECT_AW = 4
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  busy,
    input  logic                  commit,
    input  op_e                   commit_kind,
    input  logic [AW-1:0]         tgt_addr,
    input  logic [7:0]            tgt_data,
    input  logic [AW-1:0]         sect_addr,
    input  logic [NPROT-1:0]      prot_mask,
    input  logic [NPROT-1:0][7:0] prot_data,
    input  logic [AW-1:0]         rd_addr,
    output logic [7:0]            rd_data,
    output logic [NPROT*8-1:0]    prot_q
);

    localparam int DEPTH = 1 << AW;

    logic [7:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) cells[i] <= 8'hFF;
        end else if (commit) begin
            case (commit_kind)
                OP_PROG: cells[tgt_addr] <= cells[tgt_addr] & tgt_data;
                OP_SECT: begin
                    for (int i = 0; i < DEPTH; i++) begin
                        if ((AW'(i) >> SECT_AW) == (sect_addr >> SECT_AW))
                            cells[i] <= 8'hFF;
                    end
                end
                OP_CHIP: begin
                    for (int i = 0; i < DEPTH; i++) cells[i] <= 8'hFF;
                end
                default: ;
            endcase
        end
    end

    generate
        for (genvar g = 0; g < NPROT; g++) begin : g_prot
            logic [7:0] pbyte;
            always_ff @(posedge clk) begin
                if (rst) begin
                    pbyte <= 8'hFF;
                end else if (commit && commit_kind == OP_PROT && prot_mask[g]) begin
                    pbyte <= pbyte & prot_data[g];
                end
            end
            assign prot_q[g*8 +: 8] = pbyte;
        end
    endgenerate

    assign rd_data = busy ? 8'hFF : cells[rd_addr];

endmodule

// File: rtl/flash_seq.sv
module flash_seq
    import flash_seq_pkg::*;
#(
    parameter int AW      = 8,
    parameter int SECT_AW = 4,
    parameter int T_START = 20,
    parameter int T_PROG  = 6,
    parameter int T_SECT  = 40,
    parameter int T_CHIP  = 60
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 pwr_down,
    input  logic                 ctl_we,
    input  logic [4:0]           ctl_wdata,
    input  logic [AW-1:0]        mem_addr,
    input  logic                 mem_we,
    input  logic [7:0]           mem_wdata,
    output logic [7:0]           mem_rdata,
    output logic                 busy,
    output logic                 suspended,
    output logic [2:0]           op_sel,
    output logic [NPROT*8-1:0]   prot_q
);

    localparam int TMAX = max_of4(T_START, T_PROG, T_SECT, T_CHIP);
    localparam int CW   = $clog2(TMAX + 1);

    op_e                   sel_q;
    logic                  commit;
    op_e                   commit_kind;
    logic [AW-1:0]         tgt_addr;
    logic [7:0]            tgt_data;
    logic [AW-1:0]         sect_addr;
    logic [NPROT-1:0]      prot_mask;
    logic [NPROT-1:0][7:0] prot_data;

    flash_seq_fsm #(
        .AW      (AW),
        .CW      (CW),
        .T_START (T_START),
        .T_PROG  (T_PROG),
        .T_SECT  (T_SECT),
        .T_CHIP  (T_CHIP)
    ) u_fsm (
        .clk         (clk),
        .rst         (rst),
        .pwr_down    (pwr_down),
        .ctl_we      (ctl_we),
        .ctl_wdata   (ctl_wdata),
        .mem_we      (mem_we),
        .mem_addr    (mem_addr),
        .mem_wdata   (mem_wdata),
        .busy        (busy),
        .suspended   (suspended),
        .op_sel      (sel_q),
        .commit      (commit),
        .commit_kind (commit_kind),
        .tgt_addr    (tgt_addr),
        .tgt_data    (tgt_data),
        .sect_addr   (sect_addr),
        .prot_mask   (prot_mask),
        .prot_data   (prot_data)
    );

    flash_seq_store #(
        .AW      (AW),
        .SECT_AW (SECT_AW)
    ) u_store (
        .clk         (clk),
        .rst         (rst),
        .busy        (busy),
        .commit      (commit),
        .commit_kind (commit_kind),
        .tgt_addr    (tgt_addr),
        .tgt_data    (tgt_data),
        .sect_addr   (sect_addr),
        .prot_mask   (prot_mask),
        .prot_data   (prot_data),
        .rd_addr     (mem_addr),
        .rd_data     (mem_rdata),
        .prot_q      (prot_q)
    );

    assign op_sel = sel_q;

endmodule

// File: rtl/flash_seq_chk.sv
module flash_seq_chk
    import flash_seq_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       pwr_down,
    input logic       ctl_we,
    input logic [4:0] ctl_wdata,
    input logic [7:0] mem_rdata,
    input logic       busy,
    input logic       suspended,
    input logic [2:0] op_sel
);

    p_ff_while_busy_r2: assert property (@(posedge clk) disable iff (rst)
        busy |-> mem_rdata == 8'hFF);

    p_pwr_forces_busy_r1: assert property (@(posedge clk) disable iff (rst)
        pwr_down |=> busy);

    p_susp_not_busy_r10: assert property (@(posedge clk) disable iff (rst)
        (suspended && op_sel != 3'd1) |-> !busy);

    p_sel_self_clear_r13: assert property (@(posedge clk) disable iff (rst)
        ($fell(busy) && !suspended) |-> op_sel == 3'd0);

    p_chip_start_busy_r6: assert property (@(posedge clk) disable iff (rst)
        (ctl_we && ctl_wdata[3] && ctl_wdata[2:0] == 3'd3 && !busy && !suspended && !pwr_down)
        |=> busy);

    p_resume_busy_r12: assert property (@(posedge clk) disable iff (rst)
        (suspended && !busy && op_sel == 3'd2 && ctl_we && ctl_wdata[3]
         && ctl_wdata[2:0] == 3'd0 && !pwr_down)
        |=> (busy && !suspended));

endmodule

bind flash_seq flash_seq_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .pwr_down  (pwr_down),
    .ctl_we    (ctl_we),
    .ctl_wdata (ctl_wdata),
    .mem_rdata (mem_rdata),
    .busy      (busy),
    .suspended (suspended),
    .op_sel    (op_sel)
);

// File: tb/flash_seq_bench.sv
module flash_seq_bench;

    localparam int AW      = 8;
    localparam int T_START = 20;
    localparam int T_PROG  = 6;
    localparam int T_SECT  = 40;
    localparam int T_CHIP  = 60;
    localparam int PRE_SUSP = 11;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          pwr_down = 1'b0;
    logic          ctl_we = 1'b0;
    logic [4:0]    ctl_wdata = '0;
    logic [AW-1:0] mem_addr = '0;
    logic          mem_we = 1'b0;
    logic [7:0]    mem_wdata = '0;
    logic [7:0]    mem_rdata;
    logic          busy;
    logic          suspended;
    logic [2:0]    op_sel;
    logic [31:0]   prot_q;

    int n_checks = 0;
    int n_fail   = 0;

    always #10 clk = ~clk;

    flash_seq #(
        .AW (AW), .SECT_AW (4), .T_START (T_START),
        .T_PROG (T_PROG), .T_SECT (T_SECT), .T_CHIP (T_CHIP)
    ) u_flash_seq (
        .clk (clk), .rst (rst), .pwr_down (pwr_down),
        .ctl_we (ctl_we), .ctl_wdata (ctl_wdata),
        .mem_addr (mem_addr), .mem_we (mem_we), .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata), .busy (busy), .suspended (suspended),
        .op_sel (op_sel), .prot_q (prot_q)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic ctl(input logic [4:0] w);
        ctl_wdata = w;
        ctl_we = 1'b1;
        @(negedge clk);
        ctl_we = 1'b0;
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        mem_addr = a;
        mem_wdata = d;
        mem_we = 1'b1;
        @(negedge clk);
        mem_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        mem_addr = a;
        #1;
        d = mem_rdata;
    endtask

    task automatic count_busy(output int n);
        n = 0;
        while (busy && n < 1000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic prog_byte(input logic [7:0] a, input logic [7:0] d);
        int n;
        ctl(5'b00001);
        wr(a, d);
        ctl(5'b01001);
        count_busy(n);
        chk("R4 program duration", n, T_PROG);
    endtask

    task automatic t_reset;
        int n;
        logic [7:0] d;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        rd(8'h00, d);
        chk("R2 read during startup", d, 8'hFF);
        chk("R13 op_sel after reset", op_sel, 3'd0);
        count_busy(n);
        chk("R1 startup busy cycles", n, T_START);
        rd(8'h00, d);
        chk("R2 erased after reset", d, 8'hFF);
        chk("R7 prot after reset", prot_q, 32'hFFFF_FFFF);
    endtask

    task automatic t_unselected_write;
        logic [7:0] d;
        wr(8'h10, 8'h00);
        chk("R8 no busy without selection", busy, 1'b0);
        rd(8'h10, d);
        chk("R8 unselected write dropped", d, 8'hFF);
    endtask

    task automatic t_program;
        int n;
        logic [7:0] d;
        ctl(5'b00001);
        chk("R13 op_sel shows program", op_sel, 3'd1);
        chk("R3 no busy before target", busy, 1'b0);
        wr(8'h12, 8'hA5);
        chk("R3 busy after target latch", busy, 1'b1);
        rd(8'h12, d);
        chk("R2 read while loading", d, 8'hFF);
        ctl(5'b01001);
        count_busy(n);
        chk("R4 program duration", n, T_PROG);
        rd(8'h12, d);
        chk("R4 programmed value", d, 8'hA5);
        chk("R13 op_sel cleared", op_sel, 3'd0);
        prog_byte(8'h12, 8'h0F);
        rd(8'h12, d);
        chk("R4 AND with old value", d, 8'h05);
    endtask

    task automatic t_write_drop;
        int n;
        logic [7:0] d;
        ctl(5'b00001);
        wr(8'h40, 8'h3C);
        ctl(5'b01001);
        rd(8'h41, d);
        chk("R2 read while executing", d, 8'hFF);
        wr(8'h41, 8'h00);
        count_busy(n);
        chk("R4 program duration with drop", n, T_PROG - 1);
        rd(8'h41, d);
        chk("R8 write during exec dropped", d, 8'hFF);
        rd(8'h40, d);
        chk("R4 target programmed", d, 8'h3C);
    endtask

    task automatic t_empty_go;
        logic [7:0] d;
        ctl(5'b01001);
        chk("R9 empty program no busy", busy, 1'b0);
        chk("R9 op_sel zero", op_sel, 3'd0);
        ctl(5'b00010);
        chk("R13 op_sel shows sector", op_sel, 3'd2);
        ctl(5'b01010);
        chk("R9 empty sector no busy", busy, 1'b0);
        @(negedge clk);
        chk("R9 busy stays low", busy, 1'b0);
        chk("R9 op_sel cleared", op_sel, 3'd0);
        rd(8'h12, d);
        chk("R9 array unchanged", d, 8'h05);
    endtask

    task automatic t_sector;
        int n;
        logic [7:0] d;
        prog_byte(8'h25, 8'h11);
        prog_byte(8'h30, 8'h00);
        ctl(5'b00010);
        wr(8'h2A, 8'h00);
        chk("R3 busy after sector target", busy, 1'b1);
        ctl(5'b01010);
        count_busy(n);
        chk("R5 sector duration", n, T_SECT);
        rd(8'h25, d);
        chk("R5 sector byte erased", d, 8'hFF);
        rd(8'h12, d);
        chk("R5 lower sector kept", d, 8'h05);
        rd(8'h30, d);
        chk("R5 upper sector kept", d, 8'h00);
        chk("R13 op_sel cleared after erase", op_sel, 3'd0);
    endtask

    task automatic t_chip;
        int n;
        logic [7:0] d;
        ctl(5'b01011);
        chk("R3 chip busy on start", busy, 1'b1);
        count_busy(n);
        chk("R6 chip duration", n, T_CHIP);
        rd(8'h12, d);
        chk("R6 chip erased 0x12", d, 8'hFF);
        rd(8'h30, d);
        chk("R6 chip erased 0x30", d, 8'hFF);
    endtask

    task automatic t_prot;
        int n;
        logic [7:0] d;
        ctl(5'b00100);
        wr(8'h02, 8'hF0);
        chk("R3 busy after prot target", busy, 1'b1);
        wr(8'h00, 8'h3C);
        ctl(5'b01100);
        count_busy(n);
        chk("R7 prot duration", n, T_PROG);
        chk("R7 prot bytes", prot_q, 32'hFFF0_FF3C);
        rd(8'h02, d);
        chk("R7 array untouched", d, 8'hFF);
        ctl(5'b00100);
        wr(8'h06, 8'h0F);
        ctl(5'b01100);
        count_busy(n);
        chk("R7 prot AND update", prot_q, 32'hFF00_FF3C);
    endtask

    task automatic t_suspend;
        int n;
        logic [7:0] d;
        prog_byte(8'h30, 8'h12);
        ctl(5'b00010);
        wr(8'h35, 8'h00);
        ctl(5'b01010);
        repeat (PRE_SUSP - 1) @(negedge clk);
        chk("R12 busy before suspend", busy, 1'b1);
        ctl(5'b10000);
        chk("R10 busy low in suspend", busy, 1'b0);
        chk("R10 suspended high", suspended, 1'b1);
        rd(8'h30, d);
        chk("R10 sector not yet erased", d, 8'h12);
        ctl(5'b01011);
        chk("R11 chip ignored busy", busy, 1'b0);
        chk("R11 chip ignored op_sel", op_sel, 3'd2);
        ctl(5'b00100);
        chk("R11 prot ignored op_sel", op_sel, 3'd2);
        ctl(5'b00001);
        chk("R13 nested program op_sel", op_sel, 3'd1);
        wr(8'h50, 8'h77);
        chk("R11 nested busy", busy, 1'b1);
        ctl(5'b01001);
        count_busy(n);
        chk("R11 nested program duration", n, T_PROG);
        chk("R11 back in suspend", suspended, 1'b1);
        chk("R13 op_sel back to sector", op_sel, 3'd2);
        rd(8'h50, d);
        chk("R11 nested program value", d, 8'h77);
        ctl(5'b01000);
        chk("R12 suspended cleared", suspended, 1'b0);
        count_busy(n);
        chk("R12 remaining erase cycles", n, T_SECT - PRE_SUSP);
        rd(8'h30, d);
        chk("R12 sector erased after resume", d, 8'hFF);
        rd(8'h50, d);
        chk("R12 other sector kept", d, 8'h77);
        chk("R13 op_sel cleared after resume", op_sel, 3'd0);
    endtask

    task automatic t_pwr;
        int n;
        logic [7:0] d;
        pwr_down = 1'b1;
        @(negedge clk);
        chk("R1 busy in power-down", busy, 1'b1);
        pwr_down = 1'b0;
        count_busy(n);
        chk("R1 busy after power-down", n, T_START);
        rd(8'h50, d);
        chk("R1 array kept across power-down", d, 8'h77);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_unselected_write();
        t_program();
        t_write_drop();
        t_empty_go();
        t_sector();
        t_chip();
        t_prot();
        t_suspend();
        t_pwr();
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule